// File: doc/BRIEF.md
# Deferred Condition-Flag Evaluator

This block rebuilds the four arithmetic condition flags (negative, zero, overflow, carry) after the fact. It works from three saved items: an operation class, one source operand and the result. It does not need the adder that produced the result. A pipeline that wants to skip flag computation on every instruction can store only the class, source and result, then request the flags when a branch or a status read needs them. The supported classes are logic, add, subtract, a compare at a quarter and at half the datapath width, add and subtract with an incoming extend bit, shift, and a pass-through of an already packed flag nibble.

The block also contains a small extended-precision front end for multi-word add and subtract chains. It takes two operands and the current extend bit and computes the sum or difference. It produces a new extend bit and the flags for that result. The zero flag is sticky: it can be cleared by a nonzero partial word but never set again, so a zero test covers the whole chain. Every request is a single-cycle strobe. The registered outputs appear one clock later, and an opcode outside the defined set is flagged as an error.

Top module: `lazy_flag_eval`

## Requirements
- R1: Flags are packed as C in bit 0, V in bit 1, Z in bit 2, N in bit 3. Logic class (code 0): Z is set when the result is zero. Otherwise N copies the result's top bit. V and C are zero.
- R2: Add class (code 1): N and Z follow R1. C is set when the result is unsigned-below the source. V is set when the implied first operand (result minus source) and the source have the same sign and the result's sign differs from theirs.
- R3: Subtract class (code 2): N and Z follow the result. The first operand is rebuilt as result plus source. C is set when that operand is unsigned-below the source, and V is the signed overflow of operand minus source.
- R4: The narrow compare classes (code 3 at DATA_W/4 bits, code 4 at DATA_W/2 bits) apply the subtract rules to the low bits of result and source only. N is taken from the narrow sign bit and C from the narrow borrow.
- R5: Add-with-extend class (code 5): C is set when the result is at or below the source (unsigned), with the first operand equal to result minus source minus one. Subtract-with-extend class (code 6): C is set when result plus source plus one is at or below the source. V in each is the signed overflow of that operation.
- R6: Shift class (code 7): N and Z follow the result, V is zero, and C is set whenever the recorded shifted-out value (source) is nonzero.
- R7: Pass-through class (code 8) returns the low four bits of the result input as the flag word unchanged.
- R8: Extended add (code 9) adds dst plus src plus the incoming extend bit. The new extend bit is the unsigned carry out, and C equals it.
- R9: Extended subtract (code 10) computes dst minus src minus the incoming extend bit. The new extend bit is the unsigned borrow, and C equals it.
- R10: For codes 9 and 10 the new Z is the AND of the result's zero test and bit 2 of the previous-flags input, so Z is never newly set.
- R11: A strobe with a code from 11 to 15 pulses the error output for one cycle. It leaves flags, extend bit and result unchanged, and the valid output stays low.
- R12: Outputs are registered: a strobe at one clock edge updates them at that edge and raises the valid output for one cycle. Without a strobe the outputs hold and valid is low. For codes 0 to 8 the new extend bit copies the extend input and the result output copies dst.
- R13: While synchronous reset is high, flags, extend bit, result, valid and error are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| valid_i | input | 1 | Request strobe |
| op_i | input | 4 | Operation class code |
| src_i | input | DATA_W | Source operand (shift class: shifted-out value) |
| dst_i | input | DATA_W | Result for flag classes, first operand for extended ops |
| x_i | input | 1 | Current extend bit |
| flags_i | input | 4 | Previous packed flags (Z in bit 2 for stickiness) |
| valid_o | output | 1 | Registered result valid |
| flags_o | output | 4 | Packed flags {N,Z,V,C} |
| x_o | output | 1 | New extend bit |
| result_o | output | DATA_W | Extended-op result, or dst for other classes |
| err_o | output | 1 | Unknown opcode pulse |

## Verification
The bench builds the block with DATA_W = 8. At that width the narrow compares run at 2 and 4 bits, and the sign boundary sits at 0x80, so a strided sweep of both operands plus an explicit set of edge values (0, 1, 0x7F, 0x80, 0xFF) reaches every carry and overflow corner of every class. The extended ops are swept with both extend-bit values and both previous-Z values, which exercises the sticky rule in both directions. Expected flags come from integer arithmetic on signed and unsigned values in the bench.

// File: rtl/lazyflag_pkg.sv
package lazyflag_pkg;

    typedef enum logic [3:0] {
        OP_LOGIC = 4'd0,
        OP_ADD   = 4'd1,
        OP_SUB   = 4'd2,
        OP_CMPQ  = 4'd3,
        OP_CMPH  = 4'd4,
        OP_ADDX  = 4'd5,
        OP_SUBX  = 4'd6,
        OP_SHIFT = 4'd7,
        OP_PASS  = 4'd8,
        OP_XADD  = 4'd9,
        OP_XSUB  = 4'd10
    } op_e;

    typedef struct packed {
        logic n;
        logic z;
        logic v;
        logic c;
    } ccr_t;

    function automatic logic op_known(input logic [3:0] op);
        return op <= 4'd10;
    endfunction

    function automatic logic op_is_ext(input logic [3:0] op);
        return (op == 4'd9) || (op == 4'd10);
    endfunction

endpackage

// File: rtl/lf_sub_flags.sv
module lf_sub_flags
    import lazyflag_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] res,
    input  logic [W-1:0] src,
    input  logic         bin,
    output ccr_t         fl
);
    logic [W-1:0] opnd;

    // First operand rebuilt from the result and the subtrahend
    assign opnd = res + src + W'(bin);

    always_comb begin
        fl.z = (res == '0);
        fl.n = !fl.z && res[W-1];
        fl.c = bin ? (opnd <= src) : (opnd < src);
        fl.v = (opnd[W-1] ^ res[W-1]) & (opnd[W-1] ^ src[W-1]);
    end
endmodule

// File: rtl/lf_add_flags.sv
module lf_add_flags
    import lazyflag_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] res,
    input  logic [W-1:0] src,
    input  logic         cin,
    output ccr_t         fl
);
    logic [W-1:0] opnd;

    // First addend rebuilt by removing the source and carry from the sum
    assign opnd = res - src - W'(cin);

    always_comb begin
        fl.z = (res == '0);
        fl.n = !fl.z && res[W-1];
        fl.c = cin ? (res <= src) : (res < src);
        fl.v = (src[W-1] ^ res[W-1]) & ~(opnd[W-1] ^ src[W-1]);
    end
endmodule

// File: rtl/lf_class_eval.sv
module lf_class_eval
    import lazyflag_pkg::*;
#(
    parameter int W = 32
) (
    input  op_e          cls,
    input  logic [W-1:0] src,
    input  logic [W-1:0] res,
    output ccr_t         flags
);
    localparam int NNAR = 2;

    ccr_t add_fl;
    ccr_t sub_fl;
    ccr_t nar_fl [NNAR];
    ccr_t nz_fl;

    lf_add_flags #(.W(W)) u_add (
        .res(res), .src(src), .cin(cls == OP_ADDX), .fl(add_fl)
    );

    lf_sub_flags #(.W(W)) u_sub (
        .res(res), .src(src), .bin(cls == OP_SUBX), .fl(sub_fl)
    );

    // Narrow compares: index 0 at W/4, index 1 at W/2
    for (genvar g = 0; g < NNAR; g++) begin : g_narrow
        localparam int NW = W >> (NNAR - g);
        lf_sub_flags #(.W(NW)) u_nsub (
            .res(res[NW-1:0]), .src(src[NW-1:0]), .bin(1'b0), .fl(nar_fl[g])
        );
    end

    always_comb begin
        nz_fl   = '0;
        nz_fl.z = (res == '0);
        nz_fl.n = !nz_fl.z && res[W-1];
    end

    always_comb begin
        case (cls)
            OP_LOGIC:         flags = nz_fl;
            OP_ADD, OP_ADDX:  flags = add_fl;
            OP_SUB, OP_SUBX:  flags = sub_fl;
            OP_CMPQ:          flags = nar_fl[0];
            OP_CMPH:          flags = nar_fl[1];
            OP_SHIFT:         flags = '{n: nz_fl.n, z: nz_fl.z, v: 1'b0, c: (src != '0)};
            OP_PASS:          flags = ccr_t'(res[3:0]);
            default:          flags = '0;
        endcase
    end
endmodule

// File: rtl/lf_ext_unit.sv
module lf_ext_unit
    import lazyflag_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         is_sub,
    input  logic         x_in,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] res,
    output logic         x_out,
    output op_e          cls
);
    always_comb begin
        if (is_sub) begin
            res   = a - b - W'(x_in);
            x_out = x_in ? (a <= b) : (a < b);
            cls   = x_in ? OP_SUBX : OP_SUB;
        end else begin
            res   = a + b + W'(x_in);
            x_out = x_in ? (res <= b) : (res < b);
            cls   = x_in ? OP_ADDX : OP_ADD;
        end
    end
endmodule

// File: rtl/lazy_flag_eval.sv
module lazy_flag_eval
    import lazyflag_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              valid_i,
    input  logic [3:0]        op_i,
    input  logic [DATA_W-1:0] src_i,
    input  logic [DATA_W-1:0] dst_i,
    input  logic              x_i,
    input  logic [3:0]        flags_i,
    output logic              valid_o,
    output logic [3:0]        flags_o,
    output logic              x_o,
    output logic [DATA_W-1:0] result_o,
    output logic              err_o
);
    logic              known;
    logic              is_ext;
    logic [DATA_W-1:0] ext_res;
    logic              ext_x;
    op_e               ext_cls;
    op_e               cls;
    logic [DATA_W-1:0] res_sel;
    ccr_t              ev_fl;
    ccr_t              nxt_fl;
    ccr_t              prev_fl;
    logic              nxt_x;

    assign known   = op_known(op_i);
    assign is_ext  = op_is_ext(op_i);
    assign prev_fl = ccr_t'(flags_i);

    lf_ext_unit #(.W(DATA_W)) u_ext (
        .is_sub(op_i == OP_XSUB), .x_in(x_i), .a(dst_i), .b(src_i),
        .res(ext_res), .x_out(ext_x), .cls(ext_cls)
    );

    assign cls     = is_ext ? ext_cls : op_e'(op_i);
    assign res_sel = is_ext ? ext_res : dst_i;
    assign nxt_x   = is_ext ? ext_x : x_i;

    lf_class_eval #(.W(DATA_W)) u_eval (
        .cls(cls), .src(src_i), .res(res_sel), .flags(ev_fl)
    );

    always_comb begin
        nxt_fl = ev_fl;
        if (is_ext) nxt_fl.z = ev_fl.z & prev_fl.z;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_o  <= 1'b0;
            err_o    <= 1'b0;
            flags_o  <= '0;
            x_o      <= 1'b0;
            result_o <= '0;
        end else begin
            valid_o <= valid_i && known;
            err_o   <= valid_i && !known;
            if (valid_i && known) begin
                flags_o  <= nxt_fl;
                x_o      <= nxt_x;
                result_o <= res_sel;
            end
        end
    end

    // R12: accepted strobe yields valid next cycle
    p_latency_r12: assert property (@(posedge clk) disable iff (rst)
        (valid_i && known) |=> valid_o);

    // R11: unknown code leaves outputs untouched
    p_err_hold_r11: assert property (@(posedge clk) disable iff (rst)
        err_o |-> ($stable(flags_o) && $stable(x_o) && $stable(result_o) && !valid_o));

    // R1: N and Z are exclusive outside pass-through
    p_nz_excl_r1: assert property (@(posedge clk) disable iff (rst)
        (valid_o && $past(op_i) != OP_PASS) |-> !(flags_o[3] && flags_o[2]));

    // R1: logic class clears V and C
    p_logic_vc_r1: assert property (@(posedge clk) disable iff (rst)
        (valid_o && $past(op_i) == OP_LOGIC) |-> (flags_o[1:0] == 2'b00));

    // R7: pass-through returns the stored nibble
    p_pass_r7: assert property (@(posedge clk) disable iff (rst)
        (valid_o && $past(op_i) == OP_PASS) |-> (flags_o == $past(dst_i[3:0])));

    // R10: sticky Z is never newly set
    p_sticky_z_r10: assert property (@(posedge clk) disable iff (rst)
        (valid_o && op_is_ext($past(op_i)) && !$past(flags_i[2])) |-> !flags_o[2]);

    // R9: extended subtract reports carry equal to the new extend bit
    p_ext_cx_r9: assert property (@(posedge clk) disable iff (rst)
        (valid_o && op_is_ext($past(op_i))) |-> (flags_o[0] == x_o));
endmodule

// File: tb/test_lazy_flag_eval.sv
module test_lazy_flag_eval;
    localparam int W = 8;
    localparam int M = 1 << W;

    logic         clk = 1'b0;
    logic         rst;
    logic         valid_i;
    logic [3:0]   op_i;
    logic [W-1:0] src_i;
    logic [W-1:0] dst_i;
    logic         x_i;
    logic [3:0]   flags_i;
    logic         valid_o;
    logic [3:0]   flags_o;
    logic         x_o;
    logic [W-1:0] result_o;
    logic         err_o;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    logic [3:0]   exp_f = '0;
    logic         exp_x = 1'b0;
    logic [W-1:0] exp_r = '0;

    always #4 clk = ~clk;

    lazy_flag_eval #(.DATA_W(W)) i_lazy_flag_eval (
        .clk(clk), .rst(rst), .valid_i(valid_i), .op_i(op_i), .src_i(src_i),
        .dst_i(dst_i), .x_i(x_i), .flags_i(flags_i), .valid_o(valid_o),
        .flags_o(flags_o), .x_o(x_o), .result_o(result_o), .err_o(err_o)
    );

    function automatic string tag(int op);
        case (op)
            0: return "R1";   1: return "R2";   2: return "R3";
            3, 4: return "R4";
            5, 6: return "R5";
            7: return "R6";   8: return "R7";   9: return "R8/R10";
            10: return "R9/R10";
            default: return "R11";
        endcase
    endfunction

    function automatic int sgn(int v, int w);
        return (v >= (1 << (w - 1))) ? v - (1 << w) : v;
    endfunction

    function automatic logic [3:0] f_nz(int r, int w);
        logic [3:0] f = '0;
        if (r == 0) f[2] = 1'b1;
        else if (((r >> (w - 1)) & 1) == 1) f[3] = 1'b1;
        return f;
    endfunction

    function automatic logic [3:0] f_add(int r, int s, int ci, int w);
        int m = 1 << w;
        int a = (((r - s - ci) % m) + m) % m;
        int sv = sgn(a, w) + sgn(s, w) + ci;
        logic [3:0] f = f_nz(r, w);
        f[0] = (a + s + ci) >= m;
        f[1] = (sv > m / 2 - 1) || (sv < -(m / 2));
        return f;
    endfunction

    function automatic logic [3:0] f_sub(int r, int s, int bi, int w);
        int m = 1 << w;
        int a = (r + s + bi) % m;
        int sv = sgn(a, w) - sgn(s, w) - bi;
        logic [3:0] f = f_nz(r, w);
        f[0] = a < (s + bi);
        f[1] = (sv > m / 2 - 1) || (sv < -(m / 2));
        return f;
    endfunction

    task automatic report(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // Drives one request at a falling edge and checks it one clock later
    task automatic run_vec(int op, int s, int d, bit x, logic [3:0] pf);
        bit known = (op <= 10);
        int t;
        logic [3:0] f;
        if (known) begin
            exp_x = x;
            exp_r = W'(d);
            case (op)
                0: f = f_nz(d, W);
                1: f = f_add(d, s, 0, W);
                2: f = f_sub(d, s, 0, W);
                3: f = f_sub(d & 3, s & 3, 0, 2);
                4: f = f_sub(d & 15, s & 15, 0, 4);
                5: f = f_add(d, s, 1, W);
                6: f = f_sub(d, s, 1, W);
                7: begin f = f_nz(d, W); f[0] = (s != 0); end
                8: f = 4'(d & 15);
                9: begin
                    t = d + s + int'(x);
                    exp_r = W'(t % M);
                    exp_x = (t >= M);
                    f = f_nz(t % M, W);
                    f[0] = exp_x;
                    t = sgn(d, W) + sgn(s, W) + int'(x);
                    f[1] = (t > M / 2 - 1) || (t < -(M / 2));
                    f[2] = f[2] & pf[2];
                end
                default: begin
                    t = d - s - int'(x);
                    exp_x = (t < 0);
                    exp_r = W'((t + M) % M);
                    f = f_nz((t + M) % M, W);
                    f[0] = exp_x;
                    t = sgn(d, W) - sgn(s, W) - int'(x);
                    f[1] = (t > M / 2 - 1) || (t < -(M / 2));
                    f[2] = f[2] & pf[2];
                end
            endcase
            exp_f = f;
        end
        valid_i = 1'b1;
        op_i    = 4'(op);
        src_i   = W'(s);
        dst_i   = W'(d);
        x_i     = x;
        flags_i = pf;
        @(negedge clk);
        checks++;
        if (valid_o !== known || err_o !== !known || flags_o !== exp_f ||
            x_o !== exp_x || result_o !== exp_r) begin
            errors++;
            $display("FAIL %s op=%0d s=%0h d=%0h x=%0b pf=%0h actual v=%0b e=%0b f=%0h x=%0b r=%0h expected v=%0b e=%0b f=%0h x=%0b r=%0h",
                     tag(op), op, s, d, x, pf, valid_o, err_o, flags_o, x_o, result_o,
                     known, !known, exp_f, exp_x, exp_r);
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            finish_run();
        end
    end

    initial begin
        int edges [5] = '{0, 1, 127, 128, 255};
        rst = 1'b1; valid_i = 1'b0; op_i = '0; src_i = '0; dst_i = '0;
        x_i = 1'b0; flags_i = '0;
        repeat (3) @(negedge clk);
        // R13: reset state
        report("R13", "valid", valid_o, 0);
        report("R13", "err", err_o, 0);
        report("R13", "flags", flags_o, 0);
        report("R13", "x", x_o, 0);
        report("R13", "result", result_o, 0);
        rst = 1'b0;
        @(negedge clk);

        // Edge values on every defined class, both extend and previous-Z values
        for (int op = 0; op < 11; op++)
            for (int i = 0; i < 5; i++)
                for (int j = 0; j < 5; j++)
                    for (int k = 0; k < 4; k++)
                        run_vec(op, edges[i], edges[j], k[0], {1'b0, k[1], 2'b00});

        // Strided sweep of both operands
        for (int op = 0; op < 11; op++) begin
            int reps = (op >= 9) ? 4 : 1;
            for (int k = 0; k < reps; k++)
                for (int s = 0; s < M; s += 3)
                    for (int d = 0; d < M; d += 5) begin
                        bit xx = (op >= 9) ? k[0] : bit'((s ^ d) & 1);
                        logic [3:0] pf = (op >= 9) ? {1'b0, k[1], 2'b00} : 4'((s + d) & 15);
                        run_vec(op, s, d, xx, pf);
                    end
        end

        // R11: unknown codes between good requests
        for (int op = 11; op < 16; op++) begin
            run_vec(1, 200, 100, 1'b1, 4'h0);
            run_vec(op, 55, 0, 1'b0, 4'hF);
        end

        // R12: no strobe holds outputs and drops valid
        run_vec(10, 3, 9, 1'b1, 4'h4);
        valid_i = 1'b0;
        op_i = 4'd0; dst_i = '0; src_i = 8'hFF; x_i = 1'b0;
        @(negedge clk);
        report("R12", "idle valid", valid_o, 0);
        report("R12", "idle flags", flags_o, exp_f);
        report("R12", "idle x", x_o, exp_x);
        report("R12", "idle result", result_o, exp_r);

        done = 1;
        finish_run();
    end
endmodule